// File: doc/BRIEF.md
# Banked Clock Divider Selector

This block is the digital back end of a clock distribution driver that sits behind a phase-locked oscillator. It divides a fast source clock by two and by four. Both results have an exact 50% duty cycle, whatever the duty cycle of the source. It fans them out to four banks of three outputs each. A 2-bit code moves the banks from the half-rate clock to the quarter-rate clock one at a time, starting with bank 1. The last bank always stays on the half-rate clock, so one of its outputs can be wired back to the loop as a stable feedback.

A falling edge on the clear input realigns the quarter-rate clock. An active-low enable holds every output low while it is high. A bypass input clocks the dividers from the reference clock instead of the oscillator. Any event that disturbs the feedback path opens a relock window: a code change, re-enabling the outputs, or leaving bypass. During that window `relock_pending` is high, so the surrounding logic knows the loop has to settle again.

Top module: `bcd_top`

## Requirements
- R1: The half-rate clock toggles on every rising edge of the source clock. It is high for exactly one source cycle and low for exactly one source cycle.
- R2: The quarter-rate clock is high for two source cycles and low for two. It changes only on a source edge at which the half-rate clock rises.
- R3: Bank b (b = 0..3 for banks 1..4) drives y[3b+2:3b]. All three bits of a bank are equal. The bank carries the quarter-rate clock when b < code, reading code as an unsigned number 0..3, and the half-rate clock otherwise.
- R4: y[11:9] (bank 4) carries the half-rate clock for every code.
- R5: The code is registered on each source edge. The registered value takes effect only at a source edge where the half-rate clock is high and the quarter-rate clock is low, so both clocks are low just after the switch.
- R6: The first source edge that sees clr low after it was high forces the quarter-rate clock low. Its next rising edge comes with the next rising edge of the half-rate clock. A rising or steady clr has no effect.
- R7: While oe_n is 1, all twelve outputs are 0. While oe_n is 0, the outputs follow R3. The dividers keep running while the outputs are disabled.
- R8: While test is 1, the dividers are clocked by ref_clk. While test is 0, they are clocked by vco_clk.
- R9: A change of sel, a 1-to-0 change of test, or a 1-to-0 change of oe_n, seen at a vco_clk edge, raises relock_pending from the next cycle. It stays high for exactly LOCK_CYCLES vco_clk cycles. A new event inside the window restarts the count. A 0-to-1 change of test or oe_n does not start a window.
- R10: While rst_n is 0, both divided clocks are low, y is all zero and relock_pending is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock; also times the relock window |
| ref_clk | input | 1 | Reference clock, used as the divider source in bypass |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Bank rate code (thermometer count of quarter-rate banks) |
| clr | input | 1 | Quarter-rate phase clear, acts on its falling edge |
| oe_n | input | 1 | Active-low output enable |
| test | input | 1 | Bypass: clock the dividers from ref_clk |
| y | output | 12 | Four banks of three clock outputs |
| relock_pending | output | 1 | High while the loop must settle after a disturbance |

## Verification
Every code from 0 to 3 is held long enough to see several quarter-rate periods. This shows whether a bank switches to the quarter-rate clock at exactly the right count, and that bank 4 never moves. Codes are changed at different divider phases, which tells a switch held until both clocks are low apart from one that would cut a pulse short. Clear pulses that fall at different phases tell a true falling-edge realignment apart from a level action or a reaction to the rising edge. A bypass run at half the oscillator rate shows whether the dividers really follow ref_clk. Back-to-back code changes separate a window that restarts from one that only runs to its end.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  // Divided clock pair produced by the divider stage.
  typedef struct packed {
    logic half;
    logic quarter;
  } div_t;

  // A bank runs at quarter rate when its index is below the code and it
  // is not the last bank, which always keeps the half-rate clock.
  function automatic logic bank_on_quarter(input int bank, input int code,
                                           input int banks);
    return (bank < banks - 1) && (bank < code);
  endfunction

endpackage

// File: rtl/bcd_divider.sv
module bcd_divider (
  input  logic              src_clk,
  input  logic              rst_n,
  input  logic              clr,
  output bcd_pkg::div_t     div,
  output logic              clr_fall,
  output logic              half_rise
);
  logic clr_q;
  logic half_q;
  logic quarter_q;

  // Named events for the assertions and the quarter stage
  assign clr_fall  = clr_q & ~clr;
  assign half_rise = ~half_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q     <= 1'b0;
      half_q    <= 1'b0;
      quarter_q <= 1'b0;
    end else begin
      clr_q  <= clr;
      half_q <= ~half_q;
      if (clr_fall)
        quarter_q <= 1'b0;
      else if (half_rise)
        quarter_q <= ~quarter_q;
    end
  end

  assign div.half    = half_q;
  assign div.quarter = quarter_q;

  // R2: quarter rate only rises together with the half rate
  p_quarter_aligned_r2: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(quarter_q) |-> $rose(half_q));

  // R6: a clear edge leaves the quarter-rate clock low
  p_clear_low_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
    clr_fall |=> !quarter_q);

endmodule

// File: rtl/bcd_bank_route.sv
module bcd_bank_route #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_OUTS = 3,
  localparam int SEL_W    = $clog2(NUM_BANKS),
  localparam int Y_W      = NUM_BANKS * BANK_OUTS
) (
  input  logic              src_clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  bcd_pkg::div_t     div,
  input  logic              oe_n,
  output logic [Y_W-1:0]    y
);
  logic [SEL_W-1:0]     sel_q;
  logic [SEL_W-1:0]     sel_act;
  logic                 apply_ok;
  logic [NUM_BANKS-1:0] bank_clk;

  // Switching here leaves both divided clocks low after the edge
  assign apply_ok = div.half & ~div.quarter;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      sel_act <= '0;
    end else begin
      sel_q <= sel;
      if (apply_ok)
        sel_act <= sel_q;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_clk[b] = bcd_pkg::bank_on_quarter(b, 32'(sel_act), NUM_BANKS)
                         ? div.quarter : div.half;
    assign y[b*BANK_OUTS +: BANK_OUTS] = oe_n ? '0 : {BANK_OUTS{bank_clk[b]}};
  end

  // R5: the applied code only moves when both clocks are about to be low
  p_sel_apply_r5: assert property (@(posedge src_clk) disable iff (!rst_n)
    !$stable(sel_act) |-> ($past(div.half) && !$past(div.quarter)));

  // R7: disabled outputs are all low
  p_gate_low_r7: assert property (@(posedge src_clk) disable iff (!rst_n)
    oe_n |-> (y == '0));

  // R4: last bank always carries the half-rate clock when enabled
  p_last_bank_r4: assert property (@(posedge src_clk) disable iff (!rst_n)
    !oe_n |-> (y[Y_W-1 -: BANK_OUTS] == {BANK_OUTS{div.half}}));

endmodule

// File: rtl/bcd_relock.sv
module bcd_relock #(
  parameter int SEL_W       = 2,
  parameter int LOCK_CYCLES = 64,
  localparam int CNT_W      = $clog2(LOCK_CYCLES + 1)
) (
  input  logic             vco_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             test,
  input  logic             oe_n,
  output logic             relock_pending
);
  logic [SEL_W-1:0] sel_prev;
  logic             test_prev;
  logic             oe_prev;
  logic             primed;
  logic [CNT_W-1:0] cnt;
  logic             disturb;

  // Loop-disturbing events: code change, leaving bypass, re-enable
  assign disturb = primed & ((sel != sel_prev) | (test_prev & ~test) |
                             (oe_prev & ~oe_n));

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev  <= '0;
      test_prev <= 1'b0;
      oe_prev   <= 1'b0;
      primed    <= 1'b0;
      cnt       <= '0;
    end else begin
      sel_prev  <= sel;
      test_prev <= test;
      oe_prev   <= oe_n;
      primed    <= 1'b1;
      if (disturb)
        cnt <= CNT_W'(LOCK_CYCLES);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign relock_pending = (cnt != '0);

  // R9: any disturbance opens the window on the next cycle
  p_window_opens_r9: assert property (@(posedge vco_clk) disable iff (!rst_n)
    disturb |=> relock_pending);

  // R9: the window count never exceeds its length
  p_window_bound_r9: assert property (@(posedge vco_clk) disable iff (!rst_n)
    cnt <= CNT_W'(LOCK_CYCLES));

  // R9: the window closes only after its last counted cycle
  p_window_close_r9: assert property (@(posedge vco_clk) disable iff (!rst_n)
    $fell(relock_pending) |-> ($past(cnt) == CNT_W'(1)));

endmodule

// File: rtl/bcd_top.sv
module bcd_top #(
  parameter int NUM_BANKS   = 4,
  parameter int BANK_OUTS   = 3,
  parameter int LOCK_CYCLES = 64,
  localparam int SEL_W      = $clog2(NUM_BANKS),
  localparam int Y_W        = NUM_BANKS * BANK_OUTS
) (
  input  logic             vco_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  input  logic             oe_n,
  input  logic             test,
  output logic [Y_W-1:0]   y,
  output logic             relock_pending
);
  logic          src_clk;
  bcd_pkg::div_t div;
  logic          clr_fall;
  logic          half_rise;

  // Bypass selects the reference clock as the divider source
  assign src_clk = test ? ref_clk : vco_clk;

  bcd_divider u_div (
    .src_clk   (src_clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .div       (div),
    .clr_fall  (clr_fall),
    .half_rise (half_rise)
  );

  bcd_bank_route #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_OUTS (BANK_OUTS)
  ) u_route (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .div     (div),
    .oe_n    (oe_n),
    .y       (y)
  );

  bcd_relock #(
    .SEL_W       (SEL_W),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_relock (
    .vco_clk        (vco_clk),
    .rst_n          (rst_n),
    .sel            (sel),
    .test           (test),
    .oe_n           (oe_n),
    .relock_pending (relock_pending)
  );

  // R10: reset holds every output low
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r10: assert (y == '0 && !relock_pending);
    end
  end

  // R1: half rate alternates on each source edge after a rising step
  p_half_alt_r1: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(div.half) |=> !div.half);

endmodule

// File: tb/sim_bcd_top.sv
module sim_bcd_top;
  localparam int NB   = 4;
  localparam int BO   = 3;
  localparam int YW   = NB * BO;
  localparam int LOCK = 16;

  logic          vco_clk = 1'b0;
  logic          ref_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic [1:0]    sel     = 2'd0;
  logic          clr     = 1'b0;
  logic          oe_n    = 1'b0;
  logic          test    = 1'b0;
  logic [YW-1:0] y;
  logic          relock_pending;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    ended  = 1'b0;
  string cur_req = "R1 R3 R4";

  bcd_top #(.NUM_BANKS(NB), .BANK_OUTS(BO), .LOCK_CYCLES(LOCK)) u0 (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .sel(sel),
    .clr(clr), .oe_n(oe_n), .test(test), .y(y),
    .relock_pending(relock_pending)
  );

  // 250 MHz oscillator; reference at half that rate, rising with it
  always #2 vco_clk = ~vco_clk;
  initial begin
    #2;
    forever begin ref_clk = 1'b1; #4; ref_clk = 1'b0; #4; end
  end

  wire tb_src = test ? ref_clk : vco_clk;

  // Expected-state scoreboard: {half, quarter, applied code}
  logic [3:0] exp_q[$];
  logic       m_h, m_q, m_clrp;
  logic [1:0] m_selq, m_sa;

  always @(posedge tb_src or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_q = 0; m_clrp = 0; m_selq = 0; m_sa = 0;
      exp_q.delete();
    end else begin
      logic fell, nq;
      fell = m_clrp && !clr;
      nq   = fell ? 1'b0 : (!m_h ? ~m_q : m_q);
      if (m_h && !m_q) m_sa = m_selq;
      m_selq = sel;
      m_clrp = clr;
      m_h    = ~m_h;
      m_q    = nq;
      exp_q.push_back({m_h, m_q, m_sa});
    end
  end

  // Relock window expectation in the oscillator domain
  int         m_cnt;
  bit         m_primed;
  logic [1:0] p_sel;
  logic       p_test, p_oe;
  always @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_primed = 0; p_sel = 0; p_test = 0; p_oe = 0;
    end else begin
      if (m_primed && (sel != p_sel || (p_test && !test) || (p_oe && !oe_n)))
        m_cnt = LOCK;
      else if (m_cnt > 0)
        m_cnt = m_cnt - 1;
      p_sel = sel; p_test = test; p_oe = oe_n; m_primed = 1;
    end
  end

  function automatic logic [YW-1:0] want_y(logic [3:0] st, logic dis);
    logic [YW-1:0] r;
    r = '0;
    if (!dis)
      for (int i = 0; i < YW; i++) begin
        int bank;
        bank = i / BO;
        r[i] = (bank != NB - 1 && bank < int'(st[1:0])) ? st[2] : st[3];
      end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [3:0] cur = 4'd0;
  always @(negedge vco_clk) begin
    if (mon_on) begin
      while (exp_q.size() > 0) cur = exp_q.pop_front();
      chk({cur_req, " outputs"}, 32'(y), 32'(want_y(cur, oe_n)));
      chk("R9 relock window", 32'(relock_pending), 32'(m_cnt != 0));
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge vco_clk);
  endtask

  // Move to a moment where both candidate source clocks are low
  task automatic align_low();
    @(negedge ref_clk);
    #3;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    run(5);
    chk("R10 reset outputs", 32'(y), 32'd0);
    chk("R10 reset relock", 32'(relock_pending), 32'd0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    cur_req = "R1 R2 R3 R4"; run(24);
    for (int c = 1; c < 4; c++) begin
      sel = 2'(c); cur_req = "R3 R4 R5 R9"; run(40);
    end
    // Retrigger inside the window, at another divider phase
    run(1); sel = 2'd2; cur_req = "R5 R9 retrigger"; run(8);
    sel = 2'd0; run(30);
    sel = 2'd1; run(25);
    oe_n = 1'b1; cur_req = "R7 disabled"; run(20);
    oe_n = 1'b0; cur_req = "R7 R9 reenabled"; run(30);
    sel = 2'd3; cur_req = "R3 R5"; run(30);
    clr = 1'b1; cur_req = "R6 rising clr ignored"; run(7);
    clr = 1'b0; cur_req = "R6 clear"; run(9);
    clr = 1'b1; run(1);
    clr = 1'b0; cur_req = "R6 clear other phase"; run(12);
    clr = 1'b1; run(2);
    clr = 1'b0; run(14);
    align_low(); test = 1'b1; cur_req = "R8 bypass"; run(40);
    sel = 2'd1; cur_req = "R8 R5 bypass"; run(30);
    align_low(); test = 1'b0; cur_req = "R8 R9 leave bypass"; run(30);
    finish_run();
  end
endmodule